// File: doc/BRIEF.md
# Triggered Zero-Suppressed Digitization Sequencer

This block turns event triggers into ADC conversion sequences. Each trigger arrives with a channel hit bitmap. A set bit marks a channel whose signal is above threshold. For every event, the sequencer starts the ADC once for each flagged channel, in ascending channel order, and skips every channel whose bit is clear. The conversion series for the event closes as soon as the highest flagged channel has been converted. It never walks the full channel list.

Triggers can come closer together than one full conversion series takes. A trigger that arrives while the engine is busy is therefore held in a four-entry pending queue, and queued events are served in arrival order. A trigger that finds the engine free and the queue empty starts conversion at once. When the queue is already full, the trigger is discarded, a sticky overflow flag rises and a saturating drop counter advances.

Each conversion produces one output sample. The sample carries the channel index, the charge value and the time value. The last sample of an event carries an end-of-event flag. An event whose bitmap is all zeros produces only an end-of-event pulse with the sample valid low.

Top module: `tdz_seq`

## Requirements
- R1: A trigger that arrives when no event is in progress and no event is pending is loaded on that clock edge. If its bitmap is non-zero, `adc_start_o` is high in the following cycle with `adc_chan_o` equal to the lowest set bit index.
- R2: Triggers that arrive while an event is in progress are queued, up to four events, and are digitized in the order in which they arrived.
- R3: Only channels whose bitmap bit is 1 are converted, in ascending index order. There is one `adc_start_o` cycle per flagged channel, and the next start comes only after the `adc_done_i` of the previous conversion.
- R4: The sample of the highest flagged channel carries `smp_eoe_o`=1, and no further conversion is started for that event.
- R5: One cycle after an `adc_done_i` cycle, `smp_valid_o` is 1 for one cycle. It carries the converted channel index and the `adc_charge_i` and `adc_time_i` values present in the done cycle.
- R6: An event with an all-zero bitmap issues no conversion. It produces a one-cycle `smp_eoe_o` pulse with `smp_valid_o`=0, two cycles after its trigger when it is taken from idle.
- R7: A trigger that arrives while four events are pending and no event is finishing is dropped. `ovf_o` becomes 1 and stays 1 until reset, and `drop_cnt_o` increments by one, saturating at its maximum.
- R8: A trigger that arrives in the cycle in which the current event finishes is never dropped, even when four events are pending.
- R9: `busy_o` is 1 whenever an event is being digitized or at least one event is pending, and 0 otherwise.
- R10: After synchronous reset, `adc_start_o`, `smp_valid_o`, `smp_eoe_o`, `busy_o`, `ovf_o` and `drop_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Event trigger strobe, one cycle per event |
| trig_map_i | input | NCH | Channel hit bitmap, sampled with `trig_i` |
| adc_start_o | output | 1 | Start one conversion |
| adc_chan_o | output | $clog2(NCH) | Channel to convert, valid with `adc_start_o` |
| adc_done_i | input | 1 | Conversion complete, one cycle |
| adc_charge_i | input | DW | Charge result, valid with `adc_done_i` |
| adc_time_i | input | DW | Time result, valid with `adc_done_i` |
| smp_valid_o | output | 1 | Output sample valid |
| smp_eoe_o | output | 1 | End of event marker |
| smp_chan_o | output | $clog2(NCH) | Channel index of the sample |
| smp_charge_o | output | DW | Charge of the sample |
| smp_time_o | output | DW | Time of the sample |
| busy_o | output | 1 | Event in progress or pending |
| ovf_o | output | 1 | Sticky flag, set when a trigger has been dropped |
| drop_cnt_o | output | DROPW | Saturating count of dropped triggers |

## Verification
The results of this block are due at fixed distances from their stimulus. A trigger from idle raises the first ADC start one cycle later. A conversion result appears as a sample one cycle after its done pulse. An empty event's end marker comes two cycles after its trigger. A drop shows on the flag and the counter one cycle after the rejected trigger. The bench runs a behavioural model that holds the pending events in a queue and advances it on the same rising edge as the design. At every falling edge it compares the start, channel, sample, marker, busy and drop outputs with the model. Outputs are therefore judged in the exact cycle in which they are due, never a cycle early or late. Directed checks in the same falling-edge slots pin the first start after a trigger and the empty-event marker. One further check times a trigger onto the finishing done pulse while the queue is full.

// File: rtl/tdz_pkg.sv
package tdz_pkg;

    // Engine phases: idle, about to start a conversion, waiting for its result
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_t;

    localparam int TDZ_DEF_NCH   = 32;
    localparam int TDZ_DEF_DW    = 12;
    localparam int TDZ_DEF_DEPTH = 4;
    localparam int TDZ_DEF_DROPW = 8;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdz_evt_fifo.sv
module tdz_evt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = tdz_pkg::idx_width(DEPTH);

    logic [W-1:0]  slot_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == (AW+1)'(DEPTH));
    assign dout_o  = slot_q[rd_q];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                wr_q <= wrap_inc(wr_q);
            end
            if (pop_i) begin
                rd_q <= wrap_inc(rd_q);
            end
            if (push_i && !pop_i) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (pop_i && !push_i) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push_i && wr_q == AW'(g)) begin
                    slot_q[g] <= din_i;
                end
            end
        end
    endgenerate

    AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst) (push_i && full_o) |-> pop_i); // R7
    AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst) pop_i |-> !empty_o); // R2

endmodule

// File: rtl/tdz_scan_engine.sv
module tdz_scan_engine
    import tdz_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_i,
    input  logic [NCH-1:0]            map_i,
    output logic                      ready_o,
    output logic                      active_o,
    output logic                      adc_start_o,
    output logic [idx_width(NCH)-1:0] adc_chan_o,
    input  logic                      adc_done_i,
    input  logic [DW-1:0]             adc_charge_i,
    input  logic [DW-1:0]             adc_time_i,
    output logic                      smp_valid_o,
    output logic                      smp_eoe_o,
    output logic [idx_width(NCH)-1:0] smp_chan_o,
    output logic [DW-1:0]             smp_charge_o,
    output logic [DW-1:0]             smp_time_o
);
    localparam int CW = idx_width(NCH);

    sq_state_t      state_q;
    logic [NCH-1:0] rem_q;
    logic [CW-1:0]  cur_idx;
    logic [NCH-1:0] cur_bit;
    logic [NCH-1:0] rem_after;

    function automatic logic [CW-1:0] lowest_set(input logic [NCH-1:0] v);
        logic [CW-1:0] idx;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) begin
                idx = CW'(i);
            end
        end
        return idx;
    endfunction

    always_comb begin
        cur_idx   = lowest_set(rem_q);
        cur_bit   = {{(NCH-1){1'b0}}, 1'b1} << cur_idx;
        rem_after = rem_q & ~cur_bit;
    end

    // The engine can take a new event while idle or in the cycle the current one closes
    always_comb begin
        unique case (state_q)
            SQ_IDLE: ready_o = 1'b1;
            SQ_SCAN: ready_o = (rem_q == '0);
            SQ_WAIT: ready_o = adc_done_i && (rem_after == '0);
            default: ready_o = 1'b1;
        endcase
    end

    assign active_o    = (state_q != SQ_IDLE);
    assign adc_start_o = (state_q == SQ_SCAN) && (rem_q != '0);
    assign adc_chan_o  = cur_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SQ_IDLE;
            rem_q        <= '0;
            smp_valid_o  <= 1'b0;
            smp_eoe_o    <= 1'b0;
            smp_chan_o   <= '0;
            smp_charge_o <= '0;
            smp_time_o   <= '0;
        end else begin
            smp_valid_o <= 1'b0;
            smp_eoe_o   <= 1'b0;
            unique case (state_q)
                SQ_SCAN: begin
                    if (rem_q == '0) begin
                        smp_eoe_o <= 1'b1;
                    end else begin
                        state_q <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (adc_done_i) begin
                        smp_valid_o  <= 1'b1;
                        smp_chan_o   <= cur_idx;
                        smp_charge_o <= adc_charge_i;
                        smp_time_o   <= adc_time_i;
                        smp_eoe_o    <= (rem_after == '0);
                        rem_q        <= rem_after;
                        if (rem_after != '0) begin
                            state_q <= SQ_SCAN;
                        end
                    end
                end
                default: ;
            endcase
            if (ready_o) begin
                if (load_i) begin
                    state_q <= SQ_SCAN;
                    rem_q   <= map_i;
                end else begin
                    state_q <= SQ_IDLE;
                end
            end
        end
    end

    AST_START_FLAGGED: assert property (@(posedge clk) disable iff (rst) adc_start_o |-> rem_q[adc_chan_o]); // R3
    AST_SAMPLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) smp_valid_o |-> $past(adc_done_i)); // R5
    AST_EMPTY_MARKER: assert property (@(posedge clk) disable iff (rst) (smp_eoe_o && !smp_valid_o) |-> ($past(state_q) == SQ_SCAN)); // R6

endmodule

// File: rtl/tdz_seq.sv
module tdz_seq
    import tdz_pkg::*;
#(
    parameter int NCH   = TDZ_DEF_NCH,
    parameter int DW    = TDZ_DEF_DW,
    parameter int DEPTH = TDZ_DEF_DEPTH,
    parameter int DROPW = TDZ_DEF_DROPW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      trig_i,
    input  logic [NCH-1:0]            trig_map_i,
    output logic                      adc_start_o,
    output logic [idx_width(NCH)-1:0] adc_chan_o,
    input  logic                      adc_done_i,
    input  logic [DW-1:0]             adc_charge_i,
    input  logic [DW-1:0]             adc_time_i,
    output logic                      smp_valid_o,
    output logic                      smp_eoe_o,
    output logic [idx_width(NCH)-1:0] smp_chan_o,
    output logic [DW-1:0]             smp_charge_o,
    output logic [DW-1:0]             smp_time_o,
    output logic                      busy_o,
    output logic                      ovf_o,
    output logic [DROPW-1:0]          drop_cnt_o
);
    logic           eng_ready, eng_active;
    logic           q_empty, q_full;
    logic [NCH-1:0] q_head;
    logic           bypass, q_pop, q_push, push_req, drop;
    logic           eng_load;
    logic [NCH-1:0] eng_map;

    always_comb begin
        bypass   = eng_ready && q_empty && trig_i;
        q_pop    = eng_ready && !q_empty;
        push_req = trig_i && !bypass;
        q_push   = push_req && (!q_full || q_pop);
        drop     = push_req && q_full && !q_pop;
        eng_load = q_pop || bypass;
        eng_map  = q_pop ? q_head : trig_map_i;
    end

    tdz_evt_fifo #(
        .W     (NCH),
        .DEPTH (DEPTH)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .push_i  (q_push),
        .din_i   (trig_map_i),
        .pop_i   (q_pop),
        .dout_o  (q_head),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    tdz_scan_engine #(
        .NCH (NCH),
        .DW  (DW)
    ) u_eng (
        .clk          (clk),
        .rst          (rst),
        .load_i       (eng_load),
        .map_i        (eng_map),
        .ready_o      (eng_ready),
        .active_o     (eng_active),
        .adc_start_o  (adc_start_o),
        .adc_chan_o   (adc_chan_o),
        .adc_done_i   (adc_done_i),
        .adc_charge_i (adc_charge_i),
        .adc_time_i   (adc_time_i),
        .smp_valid_o  (smp_valid_o),
        .smp_eoe_o    (smp_eoe_o),
        .smp_chan_o   (smp_chan_o),
        .smp_charge_o (smp_charge_o),
        .smp_time_o   (smp_time_o)
    );

    assign busy_o = eng_active || !q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_o      <= 1'b0;
            drop_cnt_o <= '0;
        end else if (drop) begin
            ovf_o <= 1'b1;
            if (drop_cnt_o != '1) begin
                drop_cnt_o <= drop_cnt_o + 1'b1;
            end
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf_o |=> ovf_o); // R7
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (rst) !$stable(drop_cnt_o) |-> ovf_o); // R7
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) adc_start_o |-> busy_o); // R9

endmodule

// File: tb/tb_tdz_seq.sv
module tb_tdz_seq;
    localparam int NCH   = 32;
    localparam int DW    = 12;
    localparam int DROPW = 8;
    localparam int CW    = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           trig = 1'b0;
    logic [NCH-1:0] trig_map = '0;
    logic           adc_start;
    logic [CW-1:0]  adc_chan;
    logic           adc_done = 1'b0;
    logic [DW-1:0]  adc_charge = '0;
    logic [DW-1:0]  adc_time = '0;
    logic           smp_valid, smp_eoe;
    logic [CW-1:0]  smp_chan;
    logic [DW-1:0]  smp_charge, smp_time;
    logic           busy, ovf;
    logic [DROPW-1:0] drop_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tdz_seq #(.NCH(NCH), .DW(DW), .DEPTH(4), .DROPW(DROPW)) dut (
        .clk(clk), .rst(rst), .trig_i(trig), .trig_map_i(trig_map),
        .adc_start_o(adc_start), .adc_chan_o(adc_chan), .adc_done_i(adc_done),
        .adc_charge_i(adc_charge), .adc_time_i(adc_time),
        .smp_valid_o(smp_valid), .smp_eoe_o(smp_eoe), .smp_chan_o(smp_chan),
        .smp_charge_o(smp_charge), .smp_time_o(smp_time),
        .busy_o(busy), .ovf_o(ovf), .drop_cnt_o(drop_cnt)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [NCH-1:0] mq[$];
    logic [NCH-1:0] m_cur = '0;
    int             m_ph = 0;      // 0 idle, 1 about to start, 2 converting
    bit             m_valid = 0, m_eoe = 0, m_ovf = 0;
    int             m_drop = 0;
    int             m_chan = 0;
    logic [DW-1:0]  m_q = '0, m_t = '0;

    function automatic int lowbit(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) begin
            if (v[i]) return i;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        bit rdy;
        rdy = 0;
        if (rst) begin
            mq.delete();
            m_cur = '0; m_ph = 0; m_valid = 0; m_eoe = 0; m_ovf = 0; m_drop = 0;
        end else begin
            m_valid = 0;
            m_eoe   = 0;
            if (m_ph == 0) begin
                rdy = 1;
            end else if (m_ph == 1) begin
                if (m_cur == '0) begin
                    m_eoe = 1;
                    rdy = 1;
                end else begin
                    m_ph = 2;
                end
            end else if (adc_done) begin
                m_valid = 1;
                m_chan  = lowbit(m_cur);
                m_q     = adc_charge;
                m_t     = adc_time;
                m_cur[m_chan] = 1'b0;
                m_eoe   = (m_cur == '0);
                if (m_cur == '0) rdy = 1; else m_ph = 1;
            end
            if (rdy) begin
                if (mq.size() > 0) begin
                    m_cur = mq.pop_front();
                    m_ph  = 1;
                    if (trig) mq.push_back(trig_map);
                end else if (trig) begin
                    m_cur = trig_map;
                    m_ph  = 1;
                end else begin
                    m_ph = 0;
                end
            end else if (trig) begin
                if (mq.size() < 4) mq.push_back(trig_map);
                else begin
                    m_drop++;
                    m_ovf = 1;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_start;
            exp_start = (m_ph == 1) && (m_cur != '0);
            check("R3", "adc_start", adc_start, exp_start);
            if (exp_start) check("R3", "adc_chan", adc_chan, lowbit(m_cur));
            check("R5", "smp_valid", smp_valid, m_valid);
            if (m_valid) begin
                check("R2", "smp_chan", smp_chan, m_chan);
                check("R5", "smp_charge", smp_charge, m_q);
                check("R5", "smp_time", smp_time, m_t);
            end
            check(m_valid ? "R4" : "R6", "smp_eoe", smp_eoe, m_eoe);
            check("R9", "busy", busy, (m_ph != 0) || (mq.size() != 0));
            check("R7", "ovf", ovf, m_ovf);
            check("R7", "drop_cnt", drop_cnt, m_drop);
        end
    end

    // ---------------- ADC responder ----------------
    int lat = 3;
    int adc_wait = -1;
    int seq_no = 0;
    logic [CW-1:0] adc_ch_lat = '0;

    always @(negedge clk) begin
        adc_done = 1'b0;
        if (rst) begin
            adc_wait = -1;
        end else if (adc_wait > 0) begin
            adc_wait--;
            if (adc_wait == 0) begin
                adc_done   = 1'b1;
                adc_charge = DW'(adc_ch_lat * 37 + seq_no);
                adc_time   = DW'(seq_no * 11 + 5);
                seq_no++;
                adc_wait   = -1;
            end
        end else if (adc_start) begin
            adc_ch_lat = adc_chan;
            adc_wait   = lat;
        end
    end

    // ---------------- stimulus ----------------
    task automatic fire(input logic [NCH-1:0] m);
        trig     = 1'b1;
        trig_map = m;
        @(negedge clk);
        trig     = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!busy && m_ph == 0 && mq.size() == 0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: state straight out of reset
        check("R10", "adc_start", adc_start, 0);
        check("R10", "smp_valid", smp_valid, 0);
        check("R10", "smp_eoe", smp_eoe, 0);
        check("R10", "busy", busy, 0);
        check("R10", "ovf", ovf, 0);
        check("R10", "drop_cnt", drop_cnt, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: start one cycle after a trigger from idle, lowest flagged channel first
        lat = 3;
        fire(32'h8000_0024);
        check("R1", "first start", adc_start, 1);
        check("R1", "first chan", adc_chan, 2);
        wait_idle();

        // R6: all-zero bitmap gives only a marker, two cycles after the trigger
        fire('0);
        check("R6", "no start", adc_start, 0);
        @(negedge clk);
        check("R6", "marker eoe", smp_eoe, 1);
        check("R6", "marker valid", smp_valid, 0);
        wait_idle();

        // R3/R4: fast ADC, channels at both ends
        lat = 1;
        fire(32'h8000_0001);
        wait_idle();
        fire(32'h0000_0100);
        wait_idle();

        // R2/R7: burst with a slow ADC, one active, four queued, one dropped
        lat = 25;
        fire(32'h0000_0003);
        fire(32'h0000_0010);
        fire('0);
        fire(32'h0100_0000);
        fire(32'h4000_0002);
        fire(32'h0000_0800);
        check("R7", "drop after burst", drop_cnt, 1);
        check("R7", "ovf after burst", ovf, 1);
        wait_idle();
        check("R7", "ovf sticky", ovf, 1);

        // R8: trigger in the finishing cycle of the active event while four are queued
        lat = 30;
        fire(32'h0000_0001);
        fire(32'h0000_0002);
        fire(32'h0000_0004);
        fire(32'h0000_0008);
        fire(32'h0000_0010);
        for (int i = 0; i < 200; i++) begin
            #1;
            if (adc_wait == 1) break;
            @(negedge clk);
        end
        @(negedge clk);
        fire(32'h0000_0020);
        check("R8", "no drop at finish", drop_cnt, 1);
        fire(32'h0000_0040);
        check("R7", "drop when full", drop_cnt, 2);
        wait_idle();

        // mixed spacing and latencies
        for (int k = 0; k < 40; k++) begin
            lat = 1 + int'($urandom_range(0, 12));
            fire((k % 7 == 0) ? '0 : NCH'($urandom));
            repeat ($urandom_range(0, 30)) @(negedge clk);
        end
        wait_idle();
        check("R9", "idle at end", busy, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule